// File: doc/BRIEF.md
# Bus-Invert Transmit/Receive Pair

This block cuts the switching activity of a wide parallel link. On every accepted transfer the transmit side looks at the word already on the wires and counts how many lines the new word would flip. If more than half would flip, it drives the complement of the word and raises a polarity line. If not, it drives the word as it is and lowers the polarity line. Either way, at most half of the data wires change on any one transfer.

The receive side is purely combinational. It restores the original word by complementing the wires whenever the polarity line is high. The top level joins the two halves, so the decoded output can be observed next to the encoded wires. The line count is a parameter, and the flip count comes from a recursive adder tree.

Top module: `bus_invert_link`

## Requirements
- R1: While rst_n is low, and after it is released until the first accepted transfer, bus_out and pol_out are all zeros.
- R2: A word presented with valid_in high is accepted at a rising clock edge, and its encoded form appears on bus_out/pol_out right after that same edge, which is a latency of one cycle.
- R3: The flip count is the Hamming distance between data_in and the current bus_out, not the previous raw word. When this count is greater than WIDTH/2, bus_out becomes ~data_in and pol_out becomes 1.
- R4: When the flip count is WIDTH/2 or less, including exactly WIDTH/2, bus_out becomes data_in and pol_out becomes 0.
- R5: At a clock edge with valid_in low, bus_out and pol_out keep their values.
- R6: data_out equals bus_out when pol_out is 0 and ~bus_out when pol_out is 1, so after every accepted transfer it equals the accepted word.
- R7: No accepted transfer changes more than WIDTH/2 of the bus_out lines. For example, with WIDTH=8, going from 8'h00 to 8'hFE drives 8'h01 with pol_out=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Accept data_in at this edge |
| data_in | input | WIDTH | Word to transmit |
| bus_out | output | WIDTH | Encoded data wires (registered) |
| pol_out | output | 1 | Polarity line, 1 = wires carry the complement |
| data_out | output | WIDTH | Word recovered by the receive side |

## Verification
The assertions assume that valid_in and data_in are stable, known values at every rising edge once reset is released. The bench meets this by changing inputs only on falling edges and never driving X or Z. Random words are mixed with words built at a chosen distance from the current wires: exactly WIDTH/2, WIDTH/2+1, zero and all lines. This exercises the tie rule and the inversion threshold as well as the hold behaviour with valid_in low.

// File: rtl/binv_pkg.sv
package binv_pkg;
  // Width of a count that can hold values 0..n
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/binv_popcount.sv
module binv_popcount #(
  parameter int W  = 8,
  parameter int CW = binv_pkg::cnt_w(W)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  generate
    if (W == 1) begin : g_leaf
      assign cnt = CW'(vec);
    end else begin : g_node
      localparam int LO = W / 2;
      localparam int HI = W - LO;
      localparam int CL = binv_pkg::cnt_w(LO);
      localparam int CH = binv_pkg::cnt_w(HI);
      logic [CL-1:0] cnt_lo;
      logic [CH-1:0] cnt_hi;
      binv_popcount #(.W(LO), .CW(CL)) u_lo (.vec(vec[LO-1:0]), .cnt(cnt_lo));
      binv_popcount #(.W(HI), .CW(CH)) u_hi (.vec(vec[W-1:LO]), .cnt(cnt_hi));
      assign cnt = CW'(cnt_lo) + CW'(cnt_hi);
    end
  endgenerate
endmodule

// File: rtl/binv_encoder.sv
module binv_encoder #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_in,
  input  logic [W-1:0] data_in,
  output logic [W-1:0] bus_q,
  output logic         pol_q
);
  localparam int CW   = binv_pkg::cnt_w(W);
  localparam int HALF = W / 2;

  logic [CW-1:0] flips;
  logic          invert;
  logic [W-1:0]  bus_d;
  logic          pol_d;

  // Distance from the word now on the wires
  binv_popcount #(.W(W), .CW(CW)) u_cnt (.vec(data_in ^ bus_q), .cnt(flips));

  always_comb begin
    invert = (flips > CW'(HALF));
    bus_d  = bus_q;
    pol_d  = pol_q;
    if (valid_in) begin
      bus_d = invert ? ~data_in : data_in;
      pol_d = invert;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q <= '0;
      pol_q <= 1'b0;
    end else begin
      bus_q <= bus_d;
      pol_q <= pol_d;
    end
  end

  a_r7_half_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> ($countones(bus_q ^ $past(bus_q)) <= HALF));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> ($stable(bus_q) && $stable(pol_q)));

  a_r4_tie_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && ($countones(data_in ^ bus_q) == HALF)) |=> !pol_q);

  a_r3_over_inverts: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && ($countones(data_in ^ bus_q) > HALF)) |=> pol_q);

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> ((bus_q ^ {W{pol_q}}) == $past(data_in)));
endmodule

// File: rtl/binv_decoder.sv
module binv_decoder #(
  parameter int W = 8
) (
  input  logic [W-1:0] bus_in,
  input  logic         pol_in,
  output logic [W-1:0] data_out
);
  always_comb begin
    data_out = pol_in ? ~bus_in : bus_in;
  end
endmodule

// File: rtl/bus_invert_link.sv
module bus_invert_link #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_in,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] bus_out,
  output logic             pol_out,
  output logic [WIDTH-1:0] data_out
);
  binv_encoder #(.W(WIDTH)) u_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_in (valid_in),
    .data_in  (data_in),
    .bus_q    (bus_out),
    .pol_q    (pol_out)
  );

  binv_decoder #(.W(WIDTH)) u_dec (
    .bus_in   (bus_out),
    .pol_in   (pol_out),
    .data_out (data_out)
  );

  a_r6_roundtrip: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> (data_out == $past(data_in)));

  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |-> (bus_out == '0 && !pol_out));
endmodule

// File: tb/bus_invert_link_test.sv
module bus_invert_link_test;
  localparam int W       = 8;
  localparam int CLK_T   = 10;
  localparam int N_RAND  = 400;
  localparam int LIMIT   = 200000;

  logic         clk;
  logic         rst_n;
  logic         valid_in;
  logic [W-1:0] data_in;
  logic [W-1:0] bus_out;
  logic         pol_out;
  logic [W-1:0] data_out;

  int n_run;
  int n_fail;
  logic [W-1:0] exp_bus;
  logic         exp_pol;
  logic [W-1:0] last_word;
  logic [W-1:0] prev_bus;

  bus_invert_link #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .data_in(data_in),
    .bus_out(bus_out), .pol_out(pol_out), .data_out(data_out)
  );

  initial clk = 1'b0;
  always #(CLK_T/2) clk = ~clk;

  function automatic int ones(input logic [W-1:0] v);
    int c = 0;
    for (int i = 0; i < W; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic logic [W:0] model(input logic [W-1:0] cur, input logic [W-1:0] d);
    if (ones(cur ^ d) > W/2) return {1'b1, ~d};
    return {1'b0, d};
  endfunction

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive on falling edge, sample at the next falling edge (one rising edge between)
  task automatic xfer(input logic v, input logic [W-1:0] d);
    logic [W:0] m;
    valid_in = v;
    data_in  = d;
    prev_bus = exp_bus;
    if (v) begin
      m = model(exp_bus, d);
      exp_pol = m[W];
      exp_bus = m[W-1:0];
      last_word = d;
    end
    @(negedge clk);
    if (v) begin
      check("R3/R4 encode", {pol_out, bus_out}, {exp_pol, exp_bus});
      check("R6 decode", {1'b0, data_out}, {1'b0, last_word});
      n_run++;
      if (ones(bus_out ^ prev_bus) > W/2) begin
        n_fail++;
        $display("FAIL R7 toggles actual=%0d expected<=%0d", ones(bus_out ^ prev_bus), W/2);
      end
    end else begin
      check("R5 hold", {pol_out, bus_out}, {exp_pol, exp_bus});
    end
  endtask

  initial begin
    #(CLK_T * LIMIT);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    exp_bus = '0; exp_pol = 1'b0; last_word = '0; prev_bus = '0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; valid_in = 1'b0; data_in = '0;
    #(CLK_T * 3);
    check("R1 reset", {pol_out, bus_out}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {pol_out, bus_out}, '0);

    // R7 example: 00 -> FE sends 01 inverted
    xfer(1'b1, 8'hFE);
    check("R7 example", {pol_out, bus_out}, {1'b1, 8'h01});
    // R2: single-cycle latency, data visible right after one edge
    xfer(1'b1, 8'h3C);
    // R4 tie: exactly W/2 lines differ from the wires
    xfer(1'b1, exp_bus ^ 8'h0F);
    check("R4 tie plain", {8'h0, pol_out}, 9'h0);
    // R3: W/2+1 lines differ -> inverted
    xfer(1'b1, exp_bus ^ 8'h1F);
    check("R3 over half", {8'h0, pol_out}, 9'h1);
    // R3: compare against wires, not raw word: repeat same raw word
    xfer(1'b1, last_word);
    xfer(1'b1, ~exp_bus);
    xfer(1'b1, exp_bus);
    // R5 hold with random data and valid low
    xfer(1'b0, 8'hA5);
    xfer(1'b0, 8'h5A);

    for (int k = 0; k < N_RAND; k++) begin
      logic [W-1:0] d;
      int sel;
      sel = $urandom_range(0, 5);
      case (sel)
        0: d = exp_bus ^ 8'h0F;
        1: d = exp_bus ^ 8'hF8;
        2: d = ~exp_bus;
        default: d = W'($urandom);
      endcase
      xfer(($urandom_range(0, 3) != 0), d);
    end

    // Reset mid-stream returns to zero (R1)
    rst_n = 1'b0;
    #1;
    check("R1 async reset", {pol_out, bus_out}, '0);
    exp_bus = '0; exp_pol = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    xfer(1'b1, 8'h81);
    check("R2 first word", {pol_out, bus_out}, {1'b0, 8'h81});

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule